// File: doc/BRIEF.md
# Interval Timer with Buffered Clock Divider

This block is a 32-bit interval timer. Its count rate comes from a programmable clock divider. The count direction is selectable. The counter wraps at a programmable top value. Each wrap, and each update that software forces, raises a sticky flag. The flag can drive an interrupt line.

The divider value that software writes does not take effect straight away. It is held in a buffer register and copied into the working divider only on an update. An update comes from a counter wrap or from a forced update. Software that changes the count rate and needs the change at once must force an update after writing the divider. A forced update also restarts the counter and raises the flag.

Registers are accessed through one address, a write strobe, write data and combinational read data.

Top module: `shadow_timer`

## Requirements
- R1: After reset, these registers read zero: control, event, flag, divider buffer and count. The top value reads all ones, the interrupt line is low and the counter is stopped.
- R2: The register addresses are as follows; any other address reads zero and ignores writes.
  - 0 is control: bit 0 runs the counter, bit 1 selects down-counting, bit 2 enables the interrupt.
  - 1 is event: bit 0 forces an update.
  - 2 is the flag: bit 0.
  - 3 is the divider buffer.
  - 4 is the top value.
  - 5 is the count, which is read-only.
- R3: With run set and working divider value P, the counter steps once every P+1 clocks. With run clear, the count holds.
- R4: A write to the divider buffer can be read back at once. It leaves the step rate unchanged until the next update.
- R5: When counting up, a step taken while the count equals the top value sets the count to zero and produces an update.
- R6: When counting down, a step taken while the count is zero loads the top value into the count and produces an update. Starting a down-count from zero therefore produces an update on the first step.
- R7: Writing 1 to event bit 0 makes that bit read 1 for exactly one clock. On the next clock edge an update takes place whether or not the counter runs. The update loads zero into the count when counting up, or the top value when counting down.
- R8: Every update copies the divider buffer into the working divider and restarts the divider phase. The first step after an update therefore comes P+1 clocks later.
- R9: Any update sets the flag. The flag stays set until a write to the flag register with bit 0 equal to 0. A write with bit 0 equal to 1 does not change it.
- R10: The interrupt line is high exactly while the flag and the interrupt enable are both set. It rises on the same edge that sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the divider input |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register address |
| regWrite | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| updIrq | output | 1 | Update interrupt |

## Verification
A write lands on the edge where regWrite is high, and the counter first acts on a new control value at the following edge. With run enabled at edge E0 and divider P, the count after edge Ej equals floor(j/(P+1)), wrapped over the top value. A forced update is due one edge after the event write; the flag and the interrupt change on that same edge. The bench drives on falling edges and samples combinational read data one nanosecond after a falling edge, so each expected value is compared in the exact cycle the arithmetic predicts.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTL  = 3'd0,
    ADDR_EVT  = 3'd1,
    ADDR_FLAG = 3'd2,
    ADDR_DIV  = 3'd3,
    ADDR_TOP  = 3'd4,
    ADDR_CNT  = 3'd5
  } regAddr_e;

  // control bit positions
  localparam int CTL_RUN  = 0;
  localparam int CTL_DOWN = 1;
  localparam int CTL_IEN  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic down;
    logic forceUpd;
  } tmrCtl_t;
endpackage

// File: rtl/timer_ctrl.sv
`timescale 1ns/1ps
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrite,
  input  logic [CNT_W-1:0]      regWdata,
  input  logic [CNT_W-1:0]      cntVal,
  input  logic                  updEvent,
  output tmrCtl_t               ctl,
  output logic [PSC_W-1:0]      pscPre,
  output logic [CNT_W-1:0]      reloadVal,
  output logic                  updFlag,
  output logic                  updIrq,
  output logic [CNT_W-1:0]      regRdata
);
  logic runBit, downBit, ienBit, ugPending;
  logic wrCtl, wrEvt, wrFlag, wrDiv, wrTop;

  assign wrCtl  = regWrite && (regAddr == ADDR_CTL);
  assign wrEvt  = regWrite && (regAddr == ADDR_EVT);
  assign wrFlag = regWrite && (regAddr == ADDR_FLAG);
  assign wrDiv  = regWrite && (regAddr == ADDR_DIV);
  assign wrTop  = regWrite && (regAddr == ADDR_TOP);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit    <= 1'b0;
      downBit   <= 1'b0;
      ienBit    <= 1'b0;
      ugPending <= 1'b0;
      updFlag   <= 1'b0;
      pscPre    <= '0;
      reloadVal <= '1;
    end else begin
      if (wrCtl) begin
        runBit  <= regWdata[CTL_RUN];
        downBit <= regWdata[CTL_DOWN];
        ienBit  <= regWdata[CTL_IEN];
      end
      // pending bit lives for one cycle only
      ugPending <= wrEvt && regWdata[0];
      if (wrDiv) pscPre    <= regWdata[PSC_W-1:0];
      if (wrTop) reloadVal <= regWdata;
      // a new update wins over a clear in the same cycle
      if (updEvent)                    updFlag <= 1'b1;
      else if (wrFlag && !regWdata[0]) updFlag <= 1'b0;
    end
  end

  assign ctl.run      = runBit;
  assign ctl.down     = downBit;
  assign ctl.forceUpd = ugPending;
  assign updIrq       = updFlag && ienBit;

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_CTL: begin
        regRdata[CTL_RUN]  = runBit;
        regRdata[CTL_DOWN] = downBit;
        regRdata[CTL_IEN]  = ienBit;
      end
      ADDR_EVT:  regRdata[0] = ugPending;
      ADDR_FLAG: regRdata[0] = updFlag;
      ADDR_DIV:  regRdata[PSC_W-1:0] = pscPre;
      ADDR_TOP:  regRdata = reloadVal;
      ADDR_CNT:  regRdata = cntVal;
      default:   regRdata = '0;
    endcase
  end
endmodule

// File: rtl/timer_datapath.sv
`timescale 1ns/1ps
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCtl_t          ctl,
  input  logic [PSC_W-1:0] pscPre,
  input  logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cntVal,
  output logic             updEvent
);
  logic [PSC_W-1:0] actPsc;
  logic [PSC_W-1:0] divCnt;
  logic             tick;
  logic             wrapHit;
  logic [CNT_W-1:0] restartVal;

  assign tick       = ctl.run && (divCnt == actPsc);
  assign wrapHit    = ctl.down ? (cntVal == '0) : (cntVal == reloadVal);
  assign updEvent   = ctl.forceUpd || (tick && wrapHit);
  assign restartVal = ctl.down ? reloadVal : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      actPsc <= '0;
      divCnt <= '0;
      cntVal <= '0;
    end else if (updEvent) begin
      actPsc <= pscPre;
      divCnt <= '0;
      cntVal <= restartVal;
    end else if (ctl.run) begin
      if (tick) begin
        divCnt <= '0;
        cntVal <= ctl.down ? cntVal - 1'b1 : cntVal + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/shadow_timer.sv
`timescale 1ns/1ps
module shadow_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int PSC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrite,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  output logic              updIrq
);
  tmrCtl_t          ctl;
  logic [PSC_W-1:0] pscPre;
  logic [CNT_W-1:0] reloadVal;
  logic [CNT_W-1:0] cntVal;
  logic             updEvent;
  logic             updFlag;

  timer_ctrl #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWdata(regWdata), .cntVal(cntVal), .updEvent(updEvent),
    .ctl(ctl), .pscPre(pscPre), .reloadVal(reloadVal),
    .updFlag(updFlag), .updIrq(updIrq), .regRdata(regRdata)
  );

  timer_datapath #(.CNT_W(CNT_W), .PSC_W(PSC_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pscPre(pscPre),
    .reloadVal(reloadVal), .cntVal(cntVal), .updEvent(updEvent)
  );
endmodule

// File: rtl/timer_checker.sv
`timescale 1ns/1ps
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input tmrCtl_t           ctl,
  input logic              updEvent,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CNT_W-1:0]  reloadVal,
  input logic              updFlag,
  input logic              updIrq,
  input logic              regWrite,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wdBit0
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.run && !ctl.forceUpd) |=> $stable(cntVal));

  p_up_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updEvent && !ctl.down) |=> (cntVal == '0));

  p_down_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (updEvent && ctl.down) |=> (cntVal == $past(reloadVal)));

  p_force_evt_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.forceUpd |-> updEvent);

  p_pend_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.forceUpd && !(regWrite && regAddr == ADDR_EVT && wdBit0)) |=> !ctl.forceUpd);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    updEvent |=> updFlag);

  p_irq_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    updIrq |-> updFlag);
endmodule

bind shadow_timer timer_checker #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rstN(rstN), .ctl(ctl), .updEvent(updEvent),
  .cntVal(cntVal), .reloadVal(reloadVal), .updFlag(updFlag),
  .updIrq(updIrq), .regWrite(regWrite), .regAddr(regAddr),
  .wdBit0(regWdata[0])
);

// File: tb/test_shadow_timer.sv
`timescale 1ns/1ps
module test_shadow_timer;
  localparam logic [2:0] A_CTL = 3'd0, A_EVT = 3'd1, A_FLAG = 3'd2,
                         A_DIV = 3'd3, A_TOP = 3'd4, A_CNT = 3'd5;
  localparam logic [31:0] RUN = 32'h1, DOWN = 32'h2, IEN = 32'h4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrite = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        updIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  shadow_timer i_shadow_timer (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrite(regWrite),
    .regWdata(regWdata), .regRdata(regRdata), .updIrq(updIrq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrite = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrite = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v, c1, c2;
    int t, ec;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state, R2 map
    rd(A_CTL, v);  chk("R1 ctl", v, 0);
    rd(A_EVT, v);  chk("R1 evt", v, 0);
    rd(A_FLAG, v); chk("R1 flag", v, 0);
    rd(A_DIV, v);  chk("R1 div", v, 0);
    rd(A_TOP, v);  chk("R1 top", v, 32'hFFFF_FFFF);
    rd(A_CNT, v);  chk("R1 cnt", v, 0);
    chk("R1 irq", {31'b0, updIrq}, 0);
    rd(3'd7, v);   chk("R2 unmapped", v, 0);
    wr(3'd6, 32'h55); rd(3'd6, v); chk("R2 unmapped write", v, 0);

    // R3 default rate: one step per clock
    wr(A_CTL, RUN);
    edges(10);
    rd(A_CNT, v); chk("R3 rate P=0", v, 10);
    // R4 buffered divider write
    wr(A_DIV, 3);
    rd(A_DIV, v); chk("R4 readback", v, 3);
    rd(A_CNT, c1); edges(8); rd(A_CNT, c2);
    chk("R4 rate unchanged", c2 - c1, 8);

    // R7 forced update
    wr(A_EVT, 1);
    rd(A_EVT, v); chk("R7 pending", v, 1);
    rd(A_FLAG, v); chk("R7 flag not yet", v, 0);
    edges(1);
    rd(A_EVT, v); chk("R7 selfclear", v, 0);
    rd(A_CNT, v); chk("R7 count restart", v, 0);
    rd(A_FLAG, v); chk("R9 flag on force", v, 1);
    chk("R10 irq disabled", {31'b0, updIrq}, 0);
    rd(A_CNT, c1); edges(8); rd(A_CNT, c2);
    chk("R8 new rate", c2 - c1, 2);

    // R9 flag write semantics
    wr(A_FLAG, 1); rd(A_FLAG, v); chk("R9 write1 keeps", v, 1);
    wr(A_FLAG, 0); rd(A_FLAG, v); chk("R9 write0 clears", v, 0);

    // R3 hold while stopped
    wr(A_CTL, 0);
    rd(A_CNT, c1); edges(10); rd(A_CNT, c2);
    chk("R3 hold", c2, c1);

    // R5/R8 overflow loads buffered divider
    wr(A_TOP, 4); wr(A_DIV, 0); wr(A_EVT, 1); wr(A_FLAG, 0);
    wr(A_DIV, 1);
    wr(A_CTL, RUN | IEN);
    for (int j = 1; j <= 4; j++) begin
      edges(1);
      rd(A_CNT, v); chk("R5 up count", v, j);
      rd(A_FLAG, v); chk("R5 no flag yet", v, 0);
    end
    edges(1);
    rd(A_CNT, v); chk("R5 wrap to zero", v, 0);
    rd(A_FLAG, v); chk("R5 wrap flag", v, 1);
    chk("R10 irq on wrap", {31'b0, updIrq}, 1);
    edges(4);
    rd(A_CNT, v); chk("R8 halved rate after wrap", v, 2);

    // R6 down from zero underflows on first step
    wr(A_CTL, 0); wr(A_TOP, 9); wr(A_DIV, 0); wr(A_EVT, 1); wr(A_FLAG, 0);
    wr(A_CTL, RUN | DOWN);
    edges(1);
    rd(A_CNT, v); chk("R6 underflow load", v, 9);
    rd(A_FLAG, v); chk("R6 underflow flag", v, 1);
    edges(3);
    rd(A_CNT, v); chk("R6 down count", v, 6);

    // R7/R10 forced update while stopped in down mode
    wr(A_CTL, DOWN | IEN); wr(A_FLAG, 0);
    chk("R10 irq low after clear", {31'b0, updIrq}, 0);
    wr(A_EVT, 1);
    chk("R10 irq not before update", {31'b0, updIrq}, 0);
    edges(1);
    chk("R10 irq at update", {31'b0, updIrq}, 1);
    rd(A_CNT, v); chk("R7 down restart", v, 9);

    // sweep: both directions, divider 0..3, top 1..3
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 4; p++) begin
        for (int r = 1; r < 4; r++) begin
          wr(A_CTL, d ? DOWN : 0);
          wr(A_TOP, r); wr(A_DIV, p); wr(A_EVT, 1); wr(A_FLAG, 0);
          wr(A_CTL, RUN | (d ? DOWN : 0));
          for (int j = 0; j < 12; j++) begin
            t = j / (p + 1);
            ec = d ? (r - (t % (r + 1))) : (t % (r + 1));
            rd(A_CNT, v);
            chk(d ? "R6 sweep count" : "R5 sweep count", v, ec);
            rd(A_FLAG, v);
            chk("R9 sweep flag", v, (t >= r + 1) ? 1 : 0);
            edges(1);
          end
        end
      end
    end

    finish_run();
  end
endmodule